// File: doc/BRIEF.md
# Write-Back Line Buffer with Least-Recently-Used Replacement

This block sits between a simple on-chip request/response slave port and the command port of a memory controller. It keeps a small number of recently used lines so that reads and writes which land in a kept line are served without touching memory. Written data stays in the buffer, and the line is marked dirty, until the line is chosen for replacement.

On a miss the block picks the least recently used buffer as the victim. If the victim holds unflushed write data, the victim is first written back as a full line. The new line is then read from memory and the original request is completed from the buffer. A bypass input sends every access straight to memory as a single command and leaves the buffers untouched. Only one downstream command is in flight at a time. The upstream master holds its request until it sees a one-cycle ready pulse.

Addresses are byte addresses. Bits [1:0] select the byte, bits [3:2] select the word within a 4-word line, and the upper bits form the line address used as the tag and as the downstream command address. Word w of a line occupies bits [32w+31:32w] of the line-wide downstream data.

Top module: `wb_line_buffer`

## Requirements
- R1: A non-bypass read whose line is held returns that buffered word with req_ready high exactly one cycle after the request is presented, and it issues no downstream command.
- R2: On a miss the victim is the buffer used least recently, where a hit or a fill counts as a use. After reset, empty buffers are taken before any filled buffer is replaced.
- R3: A dirty victim is written back first. This is one write command with the victim's line address, the whole line and all byte enables set. It is followed by the read command for the requested line.
- R4: A buffer filled by a read, and not written since, is replaced with only the read command and no write command.
- R5: On the downstream side, a read fills the line with the memory data. The requested word is then returned from the filled line.
- R6: A write hit stores only the byte lanes whose req_be bit is set (bit b selects bits [8b+7:8b]). It marks the line dirty and issues no downstream command.
- R7: A write miss allocates the least recently used buffer, flushing it first if dirty, and fills it by a read. It then merges the write and keeps it dirty, and memory is not updated by that write.
- R8: While bypass is high, every access is one downstream command for the request's line, and no buffer state changes. A write carries the data in every word slot and sets only byte enable bits word*4+b for the set req_be bits b. A read returns the addressed word of the response.
- R9: At most one downstream command is outstanding. A command's signals stay unchanged while mem_cmd_valid is high and mem_cmd_ready is low.
- R10: req_ready is a single-cycle pulse, and rsp_rdata holds the read result while it is high.
- R11: After reset no buffer is valid, and req_ready and mem_cmd_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bypass | input | 1 | Send accesses straight to memory |
| req_valid | input | 1 | Request present, held until req_ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte lane enables for writes |
| req_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read data |
| mem_cmd_valid | output | 1 | Downstream command valid |
| mem_cmd_ready | input | 1 | Downstream command accepted |
| mem_cmd_write | output | 1 | 1 = line write, 0 = line read |
| mem_cmd_addr | output | 12 | Line address |
| mem_cmd_wdata | output | 128 | Line write data |
| mem_cmd_be | output | 16 | Byte enables for the line |
| mem_rsp_valid | input | 1 | Downstream response valid |
| mem_rsp_data | input | 128 | Line read data |

## Verification
The buffer is driven with cold read misses, hits to other words of a held line, and partial-lane write hits. These show whether data comes from the buffer or from memory, and whether byte lanes are merged correctly. A sequence of fills, a hit on the oldest line and further misses tells true recency order apart from fill order. It also separates clean victims, which issue one read, from dirty victims, which issue a write then a read. Write misses, bypass reads of a line that is dirty in the buffer, and bypass partial writes separate the allocate-and-merge path from the direct memory path. They also show that bypass leaves the kept lines intact.

// File: rtl/wb_line_buffer.sv
module wb_line_buffer #(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int NBUF       = 4
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               bypass,
  input  logic                               req_valid,
  input  logic                               req_write,
  input  logic [ADDR_W-1:0]                  req_addr,
  input  logic [DATA_W-1:0]                  req_wdata,
  input  logic [DATA_W/8-1:0]                req_be,
  output logic                               req_ready,
  output logic [DATA_W-1:0]                  rsp_rdata,
  output logic                               mem_cmd_valid,
  input  logic                               mem_cmd_ready,
  output logic                               mem_cmd_write,
  output logic [ADDR_W-$clog2(LINE_WORDS)-$clog2(DATA_W/8)-1:0] mem_cmd_addr,
  output logic [DATA_W*LINE_WORDS-1:0]       mem_cmd_wdata,
  output logic [DATA_W*LINE_WORDS/8-1:0]     mem_cmd_be,
  input  logic                               mem_rsp_valid,
  input  logic [DATA_W*LINE_WORDS-1:0]       mem_rsp_data
);
  localparam int BYTES  = DATA_W / 8;
  localparam int BYTE_W = $clog2(BYTES);
  localparam int OFF_W  = $clog2(LINE_WORDS);
  localparam int TAG_W  = ADDR_W - OFF_W - BYTE_W;
  localparam int LINE_W = DATA_W * LINE_WORDS;
  localparam int LBYTES = LINE_W / 8;
  localparam int IDX_W  = (NBUF > 1) ? $clog2(NBUF) : 1;

  typedef enum logic [2:0] {
    S_IDLE, S_FLUSH, S_FLUSH_W, S_FILL, S_FILL_W, S_BYP, S_BYP_W, S_RESP
  } state_t;

  state_t            state_q;
  logic [LINE_W-1:0] line_q [NBUF];
  logic [TAG_W-1:0]  tag_q  [NBUF];
  logic [IDX_W-1:0]  age_q  [NBUF];
  logic [NBUF-1:0]   valid_q, dirty_q;
  logic [IDX_W-1:0]  vic_q;
  logic [DATA_W-1:0] rdata_q;
  logic              ready_q;

  logic [TAG_W-1:0]  req_tag;
  logic [OFF_W-1:0]  req_off;
  logic              hit, touch_en;
  logic [IDX_W-1:0]  hit_idx, victim, touch_idx;

  assign req_tag = req_addr[ADDR_W-1 -: TAG_W];
  assign req_off = req_addr[BYTE_W +: OFF_W];

  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    victim  = '0;
    for (int i = 0; i < NBUF; i++) begin
      if (valid_q[i] && tag_q[i] == req_tag) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
      if (age_q[i] == IDX_W'(NBUF - 1)) victim = IDX_W'(i);
    end
  end

  always_comb begin
    touch_en  = 1'b0;
    touch_idx = hit_idx;
    if (state_q == S_IDLE && req_valid && !bypass && hit) begin
      touch_en = 1'b1;
    end else if (state_q == S_FILL_W && mem_rsp_valid) begin
      touch_en  = 1'b1;
      touch_idx = vic_q;
    end
  end

  assign req_ready     = ready_q;
  assign rsp_rdata     = rdata_q;
  assign mem_cmd_valid = state_q == S_FLUSH || state_q == S_FILL || state_q == S_BYP;
  assign mem_cmd_write = state_q == S_FLUSH || (state_q == S_BYP && req_write);
  assign mem_cmd_addr  = (state_q == S_FLUSH) ? tag_q[vic_q] : req_tag;
  assign mem_cmd_wdata = (state_q == S_FLUSH) ? line_q[vic_q] : {LINE_WORDS{req_wdata}};
  assign mem_cmd_be    = (state_q == S_FLUSH) ? {LBYTES{1'b1}} :
                         (state_q == S_BYP && req_write) ?
                           (LBYTES'(req_be) << (int'(req_off) * BYTES)) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NBUF; i++) age_q[i] <= IDX_W'(NBUF - 1 - i);
    end else if (touch_en) begin
      for (int i = 0; i < NBUF; i++) begin
        if (IDX_W'(i) == touch_idx) age_q[i] <= '0;
        else if (age_q[i] < age_q[touch_idx]) age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      valid_q <= '0;
      dirty_q <= '0;
      vic_q   <= '0;
      rdata_q <= '0;
      ready_q <= 1'b0;
      for (int i = 0; i < NBUF; i++) begin
        line_q[i] <= '0;
        tag_q[i]  <= '0;
      end
    end else begin
      ready_q <= 1'b0;
      case (state_q)
        S_IDLE: if (req_valid) begin
          if (bypass) begin
            state_q <= S_BYP;
          end else if (hit) begin
            rdata_q <= line_q[hit_idx][int'(req_off)*DATA_W +: DATA_W];
            if (req_write) begin
              for (int b = 0; b < BYTES; b++)
                if (req_be[b])
                  line_q[hit_idx][int'(req_off)*DATA_W + b*8 +: 8] <= req_wdata[b*8 +: 8];
              dirty_q[hit_idx] <= 1'b1;
            end
            ready_q <= 1'b1;
            state_q <= S_RESP;
          end else begin
            vic_q   <= victim;
            state_q <= (valid_q[victim] && dirty_q[victim]) ? S_FLUSH : S_FILL;
          end
        end
        S_FLUSH:   if (mem_cmd_ready) state_q <= S_FLUSH_W;
        S_FLUSH_W: if (mem_rsp_valid) begin
          dirty_q[vic_q] <= 1'b0;
          valid_q[vic_q] <= 1'b0;
          state_q        <= S_FILL;
        end
        S_FILL:    if (mem_cmd_ready) state_q <= S_FILL_W;
        S_FILL_W:  if (mem_rsp_valid) begin
          line_q[vic_q]  <= mem_rsp_data;
          tag_q[vic_q]   <= req_tag;
          valid_q[vic_q] <= 1'b1;
          dirty_q[vic_q] <= 1'b0;
          state_q        <= S_IDLE;
        end
        S_BYP:     if (mem_cmd_ready) state_q <= S_BYP_W;
        S_BYP_W:   if (mem_rsp_valid) begin
          rdata_q <= mem_rsp_data[int'(req_off)*DATA_W +: DATA_W];
          ready_q <= 1'b1;
          state_q <= S_RESP;
        end
        default:   state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wb_line_buffer_chk.sv
module wb_line_buffer_chk #(
  parameter int TAG_W  = 12,
  parameter int LINE_W = 128,
  parameter int NBUF   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bypass,
  input logic              req_valid,
  input logic              req_ready,
  input logic              mem_cmd_valid,
  input logic              mem_cmd_ready,
  input logic              mem_cmd_write,
  input logic [TAG_W-1:0]  mem_cmd_addr,
  input logic [LINE_W-1:0] mem_cmd_wdata,
  input logic [LINE_W/8-1:0] mem_cmd_be,
  input logic              mem_rsp_valid,
  input logic [NBUF-1:0]   valid_q,
  input logic [NBUF-1:0]   dirty_q,
  input logic              in_idle
);
  logic [1:0] outst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) outst <= '0;
    else outst <= outst + 2'((mem_cmd_valid && mem_cmd_ready) ? 1 : 0)
                        - 2'(mem_rsp_valid ? 1 : 0);
  end

  // R9
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cmd_valid |-> outst == 2'd0);

  // R9
  rsp_expected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |-> outst == 2'd1);

  // R9
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cmd_valid && !mem_cmd_ready |=> mem_cmd_valid && $stable(mem_cmd_write)
      && $stable(mem_cmd_addr) && $stable(mem_cmd_wdata) && $stable(mem_cmd_be));

  // R10
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready);

  // R8
  bypass_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle && req_valid && bypass |=> $stable(valid_q) && $stable(dirty_q));

  // R6
  dirty_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dirty_q & ~valid_q) == '0);
endmodule

bind wb_line_buffer wb_line_buffer_chk #(
  .TAG_W(TAG_W), .LINE_W(LINE_W), .NBUF(NBUF)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bypass(bypass), .req_valid(req_valid),
  .req_ready(req_ready), .mem_cmd_valid(mem_cmd_valid),
  .mem_cmd_ready(mem_cmd_ready), .mem_cmd_write(mem_cmd_write),
  .mem_cmd_addr(mem_cmd_addr), .mem_cmd_wdata(mem_cmd_wdata),
  .mem_cmd_be(mem_cmd_be), .mem_rsp_valid(mem_rsp_valid),
  .valid_q(valid_q), .dirty_q(dirty_q), .in_idle(state_q == S_IDLE)
);

// File: tb/test_wb_line_buffer.sv
module test_wb_line_buffer;
  localparam int LINE_W = 128;

  logic clk = 0, rst_n = 0, bypass = 0;
  logic req_valid = 0, req_write = 0;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_be = '0;
  logic req_ready;
  logic [31:0] rsp_rdata;
  logic mem_cmd_valid, mem_cmd_ready, mem_cmd_write;
  logic [11:0] mem_cmd_addr;
  logic [LINE_W-1:0] mem_cmd_wdata;
  logic [15:0] mem_cmd_be;
  logic mem_rsp_valid;
  logic [LINE_W-1:0] mem_rsp_data;

  always #5 clk = ~clk;

  wb_line_buffer i_wb_line_buffer (.*);

  function automatic logic [31:0] word_of(input int line, input int w);
    return {4'hA, 12'(line), 4'h0, 4'(w), 8'h5C};
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] d,
                                        input logic [3:0] be);
    logic [31:0] r = o;
    for (int b = 0; b < 4; b++) if (be[b]) r[b*8 +: 8] = d[b*8 +: 8];
    return r;
  endfunction

  // memory model: accepts a command one cycle after it appears, answers two cycles later
  logic [LINE_W-1:0] mem [0:4095];
  logic pend, seen;
  logic [1:0] cnt;
  logic [11:0] cur_addr, wr_addr;
  int n_rd, n_wr;
  logic [1:0] hist;

  assign mem_cmd_ready = !pend && seen;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int l = 0; l < 4096; l++)
        mem[l] <= {word_of(l, 3), word_of(l, 2), word_of(l, 1), word_of(l, 0)};
      pend <= 0; seen <= 0; cnt <= 0; mem_rsp_valid <= 0; mem_rsp_data <= '0;
      n_rd <= 0; n_wr <= 0; hist <= 0; cur_addr <= 0; wr_addr <= 0;
    end else begin
      mem_rsp_valid <= 0;
      seen <= mem_cmd_valid && !mem_cmd_ready;
      if (mem_cmd_valid && mem_cmd_ready) begin
        pend <= 1; cnt <= 2; cur_addr <= mem_cmd_addr;
        hist <= {hist[0], mem_cmd_write};
        if (mem_cmd_write) begin
          n_wr <= n_wr + 1; wr_addr <= mem_cmd_addr;
          for (int b = 0; b < 16; b++)
            if (mem_cmd_be[b]) mem[mem_cmd_addr][b*8 +: 8] <= mem_cmd_wdata[b*8 +: 8];
        end else n_rd <= n_rd + 1;
      end else if (pend) begin
        cnt <= cnt - 1;
        if (cnt == 1) begin
          mem_rsp_valid <= 1; mem_rsp_data <= mem[cur_addr]; pend <= 0;
        end
      end
    end
  end

  int n_chk = 0, n_bad = 0, b_rd, b_wr, lat;
  logic [31:0] rd;
  bit done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic mark();
    b_rd = n_rd; b_wr = n_wr;
  endtask

  task automatic access(input logic wr, input logic [15:0] a, input logic [31:0] d,
                        input logic [3:0] be);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!req_ready && lat < 200);
    rd = rsp_rdata;
    req_valid = 0;
  endtask

  task automatic t_reset();
    chk("R11 req_ready", 32'(req_ready), 0);
    chk("R11 mem_cmd_valid", 32'(mem_cmd_valid), 0);
  endtask

  task automatic t_read_miss_hit();
    mark();
    access(0, 16'h0104, 0, 0);
    chk("R5 miss data", rd, word_of('h010, 1));
    chk("R5 miss reads", n_rd - b_rd, 1);
    chk("R11 cold no write", n_wr - b_wr, 0);
    @(negedge clk);
    chk("R10 ready pulse", 32'(req_ready), 0);
    chk("R10 data held", rsp_rdata, word_of('h010, 1));
    mark();
    access(0, 16'h010C, 0, 0);
    chk("R1 hit data", rd, word_of('h010, 3));
    chk("R1 hit latency", lat, 1);
    chk("R1 hit cmds", (n_rd - b_rd) + (n_wr - b_wr), 0);
  endtask

  task automatic t_write_hit();
    mark();
    access(1, 16'h0108, 32'hDEADBEEF, 4'b0101);
    chk("R6 write hit cmds", (n_rd - b_rd) + (n_wr - b_wr), 0);
    access(0, 16'h0108, 0, 0);
    chk("R6 merged", rd, merge(word_of('h010, 2), 32'hDEADBEEF, 4'b0101));
    chk("R6 memory untouched", mem['h010][64 +: 32], word_of('h010, 2));
  endtask

  task automatic t_lru_evict();
    access(0, 16'h0200, 0, 0);
    access(0, 16'h0300, 0, 0);
    access(0, 16'h0400, 0, 0);
    access(0, 16'h0100, 0, 0);
    mark();
    access(0, 16'h0500, 0, 0);
    chk("R4 clean victim no write", n_wr - b_wr, 0);
    chk("R2 miss one read", n_rd - b_rd, 1);
    mark();
    access(0, 16'h0104, 0, 0);
    chk("R2 recent line kept", (n_rd - b_rd) + (n_wr - b_wr), 0);
    access(0, 16'h0600, 0, 0);
    access(0, 16'h0700, 0, 0);
    mark();
    access(0, 16'h0804, 0, 0);
    chk("R4 clean evict", n_wr - b_wr, 0);
    chk("R5 fill data", rd, word_of('h080, 1));
    mark();
    access(0, 16'h0900, 0, 0);
    chk("R3 dirty flush count", n_wr - b_wr, 1);
    chk("R3 read after flush", n_rd - b_rd, 1);
    chk("R3 write before read", 32'(hist), 2);
    chk("R3 flush addr", 32'(wr_addr), 'h010);
    chk("R3 flushed word", mem['h010][64 +: 32], merge(word_of('h010, 2), 32'hDEADBEEF, 4'b0101));
    chk("R3 other word", mem['h010][32 +: 32], word_of('h010, 1));
  endtask

  task automatic t_write_miss();
    mark();
    access(1, 16'h0A04, 32'h12345678, 4'hF);
    chk("R7 fill read", n_rd - b_rd, 1);
    chk("R7 no write", n_wr - b_wr, 0);
    chk("R7 memory unchanged", mem['h0A0][32 +: 32], word_of('h0A0, 1));
    mark();
    access(0, 16'h0A04, 0, 0);
    chk("R7 merged data", rd, 32'h12345678);
    chk("R7 hit after", (n_rd - b_rd) + (n_wr - b_wr), 0);
  endtask

  task automatic t_bypass();
    bypass = 1;
    mark();
    access(0, 16'h0A04, 0, 0);
    chk("R8 bypass read data", rd, word_of('h0A0, 1));
    chk("R8 bypass read cmd", n_rd - b_rd, 1);
    mark();
    access(1, 16'h0B0C, 32'hCAFEF00D, 4'b1100);
    chk("R8 bypass write cmd", n_wr - b_wr, 1);
    chk("R8 bypass no read", n_rd - b_rd, 0);
    chk("R8 lanes written", mem['h0B0][96 +: 32], 32'hCAFE035C);
    chk("R8 other word", mem['h0B0][0 +: 32], word_of('h0B0, 0));
    bypass = 0;
    mark();
    access(0, 16'h0A04, 0, 0);
    chk("R8 buffer kept", rd, 32'h12345678);
    chk("R8 still hit", (n_rd - b_rd) + (n_wr - b_wr), 0);
    mark();
    access(0, 16'h0B0C, 0, 0);
    chk("R8 not allocated", n_rd - b_rd, 1);
    chk("R5 fill sees bypass write", rd, 32'hCAFE035C);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1;
    t_read_miss_hit();
    t_write_hit();
    t_lru_evict();
    t_write_miss();
    t_bypass();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule